// File: doc/BRIEF.md
# Two-Operand Integer Execute Unit

This block is the purely combinational execute stage of a small processor whose 16-bit instructions name a single destination register that also serves as the first source. The decode stage hands it the raw instruction word, the current value of the destination register and the value of the second source register. Within the same cycle the unit returns the 32-bit value to write back and a write strobe for the register file.

The unit covers several groups of operations:

- add, subtract and multiply, all wrapping modulo 2^32;
- negate and bitwise complement;
- left, logical-right and arithmetic-right shifts;
- AND, OR and XOR;
- zero test and plain copy;
- sign extension from the top bit of byte 0, 1 or 2;
- insertion of an 8-bit constant into one byte lane of the destination.

One instruction form takes a 4-bit zero-extended constant in place of the second register. Writes aimed at register zero are suppressed, so that register always reads as zero.

Top module: `acc_alu`

## Requirements
- R1: Instruction fields are fixed by position. Bits 15:12 hold the opcode and bits 11:8 the destination index. Bits 7:4 hold the second-operand field (a register index, or a 4-bit constant in the constant form). Bits 3:0 hold the function code. In the byte-insert opcodes, bits 7:0 are the 8-bit constant.
- R2: With opcode 0000, function 0000 gives dest+src, 0001 gives dest-src and 0010 gives the low 32 bits of dest*src. All three wrap with no overflow indication.
- R3: Function 0011 gives the two's complement negation of the second operand and 0111 gives its bitwise complement. The destination value does not affect either result.
- R4: Function 0100 shifts the destination left, 0101 shifts it right with zero fill, and 0110 shifts it right with copies of bit 31. The shift amount is the low 5 bits of the second operand.
- R5: Functions 1000, 1001 and 1010 give the bitwise AND, OR and XOR of the destination and the second operand.
- R6: Function 1011 gives 1 when the second operand is zero and 0 otherwise. Function 1100 copies the second operand.
- R7: Functions 1101, 1110 and 1111 sign-extend the second operand from byte 0, 1 or 2. Bits 8n+7..0 are kept and bit 8n+7 is copied into every higher bit; for example, 0x1037A2A6 extended from byte 0 gives 0xFFFFFFA6.
- R8: With opcode 0001, the second operand is bits 7:4 zero-extended to 32 bits. Only functions 0000-0110 and 1000-1010 write. Functions 0111 and 1011-1111 produce no write.
- R9: Opcodes 1100, 1101, 1110 and 1111 replace byte 0, 1, 2 or 3 of the destination with bits 7:0 and keep the other bytes.
- R10: When the destination index is 0, wr_en_o is 0.
- R11: Opcodes 0010 through 1011 never write. Whenever wr_en_o is 0, result_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 16 | Instruction word being executed |
| rd_val_i | input | 32 | Current value of the destination register |
| rs_val_i | input | 32 | Value of the second source register |
| result_o | output | 32 | Value to write back (0 when no write) |
| wr_en_o | output | 1 | Register write strobe |

## Verification
The checker watches, on every input change, the invariants that hold whatever the data:

- no write to register zero, from unused opcodes, or from the constant-form codes that have no meaning;
- a zero result whenever there is no write;
- untouched bytes around an inserted lane;
- uniform upper bits after a sign extension;
- a zero-test result of exactly 0 or 1.

The actual arithmetic values need the bench's behavioural model. That covers the sums, products and negations, the shift distances and fill bits, the byte-lane sign points, and the zero-extension of the 4-bit constant. The model is exercised with directed corner cases and a large set of pseudo-random instructions.

// File: rtl/acc_alu_pkg.sv
`timescale 1ns/1ps
package acc_alu_pkg;
  localparam int XLEN   = 32;
  localparam int LANE_W = 8;

  localparam logic [3:0] OPC_REG = 4'b0000;
  localparam logic [3:0] OPC_IMM = 4'b0001;

  typedef enum logic [3:0] {
    FN_ADD = 4'd0,  FN_SUB = 4'd1,  FN_MUL = 4'd2,  FN_NEG = 4'd3,
    FN_SHL = 4'd4,  FN_SHR = 4'd5,  FN_SAR = 4'd6,  FN_NOT = 4'd7,
    FN_AND = 4'd8,  FN_OR  = 4'd9,  FN_XOR = 4'd10, FN_ZEQ = 4'd11,
    FN_MOV = 4'd12, FN_SX0 = 4'd13, FN_SX1 = 4'd14, FN_SX2 = 4'd15
  } alu_fn_e;

  typedef enum logic [1:0] {
    SH_LEFT  = 2'b00,
    SH_RLOG  = 2'b01,
    SH_RARI  = 2'b10
  } shift_kind_e;

  function automatic logic imm_form_allowed(input alu_fn_e f);
    return (f inside {FN_ADD, FN_SUB, FN_MUL, FN_NEG, FN_SHL, FN_SHR,
                      FN_SAR, FN_AND, FN_OR, FN_XOR});
  endfunction

  function automatic logic [XLEN-1:0] twos_neg(input logic [XLEN-1:0] v);
    return (~v) + {{(XLEN-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic [XLEN-1:0] zero_flag(input logic [XLEN-1:0] v);
    return {{(XLEN-1){1'b0}}, (v == '0)};
  endfunction
endpackage

// File: rtl/acc_alu_arith.sv
`timescale 1ns/1ps
module acc_alu_arith import acc_alu_pkg::*; #(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] diff_o,
  output logic [W-1:0] prod_o,
  output logic [W-1:0] neg_o
);
  assign sum_o  = a_i + b_i;
  assign diff_o = a_i - b_i;
  assign prod_o = a_i * b_i;
  assign neg_o  = twos_neg(b_i);
endmodule

// File: rtl/acc_alu_shift.sv
`timescale 1ns/1ps
module acc_alu_shift import acc_alu_pkg::*; #(
  parameter int W  = XLEN,
  localparam int SW = $clog2(W)
) (
  input  logic [W-1:0]  val_i,
  input  logic [SW-1:0] amt_i,
  input  shift_kind_e   kind_i,
  output logic [W-1:0]  out_o
);
  always_comb begin
    unique case (kind_i)
      SH_LEFT: out_o = val_i << amt_i;
      SH_RLOG: out_o = val_i >> amt_i;
      default: out_o = W'($signed(val_i) >>> amt_i);
    endcase
  end
endmodule

// File: rtl/acc_alu_lane.sv
`timescale 1ns/1ps
module acc_alu_lane import acc_alu_pkg::*; #(
  parameter int W   = XLEN,
  localparam int NL  = W / LANE_W,
  localparam int LIW = $clog2(NL)
) (
  input  logic [W-1:0]      dst_i,
  input  logic [W-1:0]      src_i,
  input  logic [LANE_W-1:0] imm_i,
  input  logic [LIW-1:0]    ins_lane_i,
  input  logic [LIW-1:0]    sx_lane_i,
  output logic [W-1:0]      ins_o,
  output logic [W-1:0]      sx_o
);
  logic [W-1:0] sx_cand [NL];

  for (genvar g = 0; g < NL; g++) begin : g_lane
    localparam int TOP = g * LANE_W + LANE_W - 1;
    assign ins_o[g*LANE_W +: LANE_W] =
      (ins_lane_i == LIW'(g)) ? imm_i : dst_i[g*LANE_W +: LANE_W];
    if (TOP == W - 1) begin : g_full
      assign sx_cand[g] = src_i;
    end else begin : g_ext
      assign sx_cand[g] = {{(W-1-TOP){src_i[TOP]}}, src_i[TOP:0]};
    end
  end

  assign sx_o = sx_cand[sx_lane_i];
endmodule

// File: rtl/acc_alu.sv
`timescale 1ns/1ps
module acc_alu import acc_alu_pkg::*; #(
  parameter int W = XLEN
) (
  input  logic [15:0]  instr_i,
  input  logic [W-1:0] rd_val_i,
  input  logic [W-1:0] rs_val_i,
  output logic [W-1:0] result_o,
  output logic         wr_en_o
);
  localparam int SW  = $clog2(W);
  localparam int LIW = $clog2(W / LANE_W);

  logic [3:0] opc;
  logic [3:0] rd_idx;
  logic [3:0] fld_b;
  alu_fn_e    fn;

  assign opc    = instr_i[15:12];
  assign rd_idx = instr_i[11:8];
  assign fld_b  = instr_i[7:4];
  assign fn     = alu_fn_e'(instr_i[3:0]);

  // named decode events, also observed by the checker
  logic is_reg_form, is_imm_form, is_lane_ins, fn_ok, op_legal, rd_is_zero;
  assign is_reg_form = (opc == OPC_REG);
  assign is_imm_form = (opc == OPC_IMM);
  assign is_lane_ins = (opc[3:2] == 2'b11);
  assign fn_ok       = is_reg_form | (is_imm_form & imm_form_allowed(fn));
  assign op_legal    = fn_ok | is_lane_ins;
  assign rd_is_zero  = (rd_idx == 4'd0);

  logic [W-1:0] op_b;
  assign op_b = is_reg_form ? rs_val_i : {{(W-4){1'b0}}, fld_b};

  logic [W-1:0] sum_w, diff_w, prod_w, neg_w, shift_w, ins_w, sx_w;
  logic [LIW-1:0] sx_lane;
  assign sx_lane = LIW'(instr_i[1:0] - 2'd1);

  acc_alu_arith #(.W(W)) u_arith (
    .a_i(rd_val_i), .b_i(op_b),
    .sum_o(sum_w), .diff_o(diff_w), .prod_o(prod_w), .neg_o(neg_w)
  );

  acc_alu_shift #(.W(W)) u_shift (
    .val_i(rd_val_i), .amt_i(op_b[SW-1:0]),
    .kind_i(shift_kind_e'(instr_i[1:0])), .out_o(shift_w)
  );

  acc_alu_lane #(.W(W)) u_lane (
    .dst_i(rd_val_i), .src_i(op_b), .imm_i(instr_i[7:0]),
    .ins_lane_i(LIW'(opc[1:0])), .sx_lane_i(sx_lane),
    .ins_o(ins_w), .sx_o(sx_w)
  );

  logic [W-1:0] raw_res;
  always_comb begin
    if (is_lane_ins) begin
      raw_res = ins_w;
    end else begin
      unique case (fn)
        FN_ADD:                 raw_res = sum_w;
        FN_SUB:                 raw_res = diff_w;
        FN_MUL:                 raw_res = prod_w;
        FN_NEG:                 raw_res = neg_w;
        FN_SHL, FN_SHR, FN_SAR: raw_res = shift_w;
        FN_NOT:                 raw_res = ~op_b;
        FN_AND:                 raw_res = rd_val_i & op_b;
        FN_OR:                  raw_res = rd_val_i | op_b;
        FN_XOR:                 raw_res = rd_val_i ^ op_b;
        FN_ZEQ:                 raw_res = zero_flag(op_b);
        FN_MOV:                 raw_res = op_b;
        default:                raw_res = sx_w;
      endcase
    end
  end

  assign wr_en_o  = op_legal & ~rd_is_zero;
  assign result_o = wr_en_o ? raw_res : '0;
endmodule

// File: rtl/acc_alu_chk.sv
`timescale 1ns/1ps
module acc_alu_chk #(
  parameter int W = 32
) (
  input logic [15:0]  instr_i,
  input logic [W-1:0] rd_val_i,
  input logic [W-1:0] rs_val_i,
  input logic [W-1:0] result_o,
  input logic         wr_en_o,
  input logic         op_legal,
  input logic         rd_is_zero
);
  logic [3:0] c_opc, c_fn;
  assign c_opc = instr_i[15:12];
  assign c_fn  = instr_i[3:0];

  logic lanes_kept, sx_uniform;
  always_comb begin
    lanes_kept = 1'b1;
    for (int k = 0; k < W / 8; k++) begin
      if (k != int'(c_opc[1:0]) && result_o[k*8 +: 8] != rd_val_i[k*8 +: 8])
        lanes_kept = 1'b0;
    end
    sx_uniform = 1'b1;
    for (int k = 0; k < W; k++) begin
      if (k > (int'(c_fn) - 13) * 8 + 7 && result_o[k] != result_o[W-1])
        sx_uniform = 1'b0;
    end
  end

  always_comb begin
    p_r0_discard_r10: assert (instr_i[11:8] != 4'd0 || !wr_en_o)
      else $error("write to register zero");
    p_write_cause_r10: assert (!wr_en_o || (op_legal && !rd_is_zero))
      else $error("write without legal decode");
    p_quiet_result_r11: assert (wr_en_o || result_o == '0)
      else $error("nonzero result without write");
    p_unused_op_r11: assert (!(c_opc >= 4'd2 && c_opc <= 4'd11) || !wr_en_o)
      else $error("unused opcode wrote");
    p_no_imm_sext_r8: assert (!(c_opc == 4'd1 && (c_fn == 4'd7 || c_fn >= 4'd11)) || !wr_en_o)
      else $error("meaningless constant-form code wrote");
    p_lane_keep_r9: assert (!(c_opc[3:2] == 2'b11 && wr_en_o) || lanes_kept)
      else $error("byte insert disturbed another lane");
    p_sext_top_r7: assert (!(c_opc == 4'd0 && c_fn >= 4'd13 && wr_en_o) || sx_uniform)
      else $error("sign extension upper bits not uniform");
    p_zero_test_r6: assert (!(c_opc == 4'd0 && c_fn == 4'd11 && wr_en_o) ||
                            (result_o[W-1:1] == '0 && (result_o[0] == (rs_val_i == '0))))
      else $error("zero test result wrong");
  end
endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_chk (
  .instr_i(instr_i), .rd_val_i(rd_val_i), .rs_val_i(rs_val_i),
  .result_o(result_o), .wr_en_o(wr_en_o),
  .op_legal(op_legal), .rd_is_zero(rd_is_zero)
);

// File: tb/acc_alu_tb.sv
`timescale 1ns/1ps
module acc_alu_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [15:0] instr;
  logic [31:0] rd_val, rs_val, result;
  logic        wr_en;

  acc_alu u_dut (
    .instr_i(instr), .rd_val_i(rd_val), .rs_val_i(rs_val),
    .result_o(result), .wr_en_o(wr_en)
  );

  int n_vec  = 0;
  int n_miss = 0;
  bit done   = 0;

  function automatic void model(input logic [15:0] ins, input logic [31:0] d, s,
                                output logic [31:0] r, output logic w, output string tag);
    int opc = int'(ins[15:12]);
    int fn  = int'(ins[3:0]);
    logic [31:0] b;
    logic [63:0] p;
    int amt;
    r = 0; w = 0; tag = "R11";
    if (opc >= 12) begin
      r = d;
      for (int k = 0; k < 8; k++) r[(opc-12)*8 + k] = ins[k];
      w = 1; tag = "R9";
    end else if (opc <= 1) begin
      b = (opc == 0) ? s : {28'd0, ins[7:4]};
      amt = int'(b[4:0]);
      w = 1;
      case (fn)
        0: begin r = d + b; tag = "R2"; end
        1: begin r = d - b; tag = "R2"; end
        2: begin p = {32'd0, d} * {32'd0, b}; r = p[31:0]; tag = "R2"; end
        3: begin r = 32'd0 - b; tag = "R3"; end
        7: begin r = ~b; tag = "R3"; end
        4: begin r = d; repeat (amt) r = {r[30:0], 1'b0}; tag = "R4"; end
        5: begin r = d; repeat (amt) r = {1'b0, r[31:1]}; tag = "R4"; end
        6: begin r = d; repeat (amt) r = {r[31], r[31:1]}; tag = "R4"; end
        8: begin r = d & b; tag = "R5"; end
        9: begin r = d | b; tag = "R5"; end
        10: begin r = d ^ b; tag = "R5"; end
        11: begin r = (b == 0) ? 32'd1 : 32'd0; tag = "R6"; end
        12: begin r = b; tag = "R6"; end
        default: begin
          r = b;
          for (int k = (fn-13)*8 + 8; k < 32; k++) r[k] = b[(fn-13)*8 + 7];
          tag = "R7";
        end
      endcase
      if (opc == 1) begin
        tag = "R8";
        if (fn == 7 || fn >= 11) begin w = 0; r = 0; end
      end
    end
    if (ins[11:8] == 4'd0 && w) begin w = 0; r = 0; tag = "R10"; end
  endfunction

  task automatic apply(input logic [15:0] ins, input logic [31:0] d, s, input string force_tag);
    logic [31:0] er; logic ew; string tag;
    @(posedge clk);
    instr <= ins; rd_val <= d; rs_val <= s;
    @(negedge clk);
    model(ins, d, s, er, ew, tag);
    if (force_tag != "") tag = force_tag;
    n_vec++;
    if (result !== er || wr_en !== ew) begin
      n_miss++;
      $display("FAIL %s instr=%h rd=%h rs=%h: got %h/%b expected %h/%b",
               tag, ins, d, s, result, wr_en, er, ew);
    end
  endtask

  initial begin
    #4000000;
    if (!done) begin
      n_miss++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
    end
  end

  initial begin
    instr = '0; rd_val = '0; rs_val = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    n_vec++;
    if (result !== 32'd0 || wr_en !== 1'b0) begin
      n_miss++;
      $display("FAIL R10 reset state: got %h/%b expected 00000000/0", result, wr_en);
    end
    // R1: field positions, destination index and constant field
    apply(16'h0510, 32'd7, 32'd5, "R1");
    apply(16'h1A30, 32'd100, 32'hFFFF_FFFF, "R1");
    // R2: wrap and multiply truncation
    apply(16'h0100, 32'hFFFF_FFFF, 32'd1, "");
    apply(16'h0101, 32'd0, 32'd1, "");
    apply(16'h0102, 32'h0001_0001, 32'h0001_0001, "");
    // R3: destination does not matter
    apply(16'h0203, 32'hDEAD_BEEF, 32'd5, "");
    apply(16'h0203, 32'd0, 32'd5, "");
    apply(16'h0207, 32'h1234_5678, 32'h0F0F_0F0F, "");
    // R4: amounts 0, 31, high bits ignored
    apply(16'h0304, 32'h8000_0001, 32'd31, "");
    apply(16'h0305, 32'h8000_0000, 32'd31, "");
    apply(16'h0306, 32'h8000_0000, 32'd31, "");
    apply(16'h0306, 32'h8000_0000, 32'h0000_0020, "");
    apply(16'h0306, 32'h4000_0000, 32'd0, "");
    // R5
    apply(16'h0408, 32'hF0F0_F0F0, 32'hFF00_FF00, "");
    apply(16'h0409, 32'hF0F0_F0F0, 32'hFF00_FF00, "");
    apply(16'h040A, 32'hF0F0_F0F0, 32'hFF00_FF00, "");
    // R6
    apply(16'h050B, 32'h55, 32'd0, "");
    apply(16'h050B, 32'h55, 32'h8000_0000, "");
    apply(16'h050C, 32'h55, 32'hCAFE_F00D, "");
    // R7: the worked example and its neighbours
    apply(16'h060D, 32'd0, 32'h1037_A2A6, "");
    apply(16'h060E, 32'd0, 32'h1037_A2A6, "");
    apply(16'h060F, 32'd0, 32'h1037_A2A6, "");
    apply(16'h060F, 32'd0, 32'h0080_0000, "");
    // R8: constant shifts, zero-extension, no-write codes
    apply(16'h17F4, 32'd1, 32'hFFFF_FFFF, "");
    apply(16'h17F6, 32'h8000_0000, 32'd0, "");
    apply(16'h17F3, 32'd9, 32'd0, "");
    apply(16'h17FD, 32'd9, 32'hFFFF_FFFF, "");
    apply(16'h1707, 32'd9, 32'd1, "");
    apply(16'h170B, 32'd9, 32'd1, "");
    // R9: all four lanes
    apply(16'hC8AB, 32'h1122_3344, 32'd0, "");
    apply(16'hD8AB, 32'h1122_3344, 32'd0, "");
    apply(16'hE8AB, 32'h1122_3344, 32'd0, "");
    apply(16'hF8AB, 32'h1122_3344, 32'd0, "");
    // R10: register zero target
    apply(16'h0000, 32'd3, 32'd4, "");
    apply(16'hC0FF, 32'd3, 32'd4, "");
    // R11: unused opcodes
    for (int o = 2; o < 12; o++) apply({o[3:0], 12'h3A0}, 32'hAAAA_5555, 32'd7, "");
    // pseudo-random sweep
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] rs;
      rs = $urandom;
      if (i % 4 == 0) rs = rs & 32'h3F;
      if (i % 16 == 1) rs = 0;
      apply(16'($urandom), $urandom, rs, "");
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
    $finish;
  end
endmodule